// File: doc/BRIEF.md
# PoE Powered-Device Power Sequencer

This block is the digital mode controller that sits behind the analog front end of a Power-over-Ethernet powered device. Each clock it samples an 8-bit code for the input voltage (0.25 V per LSB) together with four flags from analog comparators: isolation switch fully enhanced, junction above the trip temperature, junction below the recovery temperature, and wall adapter present. From these it keeps one registered operating mode and drives the enables for the signature pull-down, the classification sink, the isolation switch, the current-limit select and the power-good sink.

Below the powered range the mode follows the voltage band. When the input crosses the turn-on level the switch closes with the inrush limit and power-good held, and it moves to full power once a minimum hold time has passed and the switch reports full enhancement. Leaving power needs a sustained undervoltage, so short dips are ignored. An overtemperature trip opens the switch, and recovery re-runs the inrush phase. A detected wall adapter overrides the switch and the classification sink.

Top module: `pd_power_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block goes to mode IDLE (code 0) and every output enable is low.
- R2: `mode_o` encodes IDLE=0, DETECT=1, CLASSIFY=2, MARK=3, INRUSH=4, POWER=5, THERMAL=6. Outside the powered modes the mode one edge after a sample is CLASSIFY for codes 51..80 and DETECT for codes 6..40 (unless R3 applies). Every other code below 142 gives IDLE.
- R3: A code in 21..50 sampled while the mode is CLASSIFY or MARK gives MARK. The same code reached from any other mode does not.
- R4: `sig_pd_o` is high exactly while the mode is DETECT.
- R5: `cls_en_o` is high exactly while the mode is CLASSIFY (subject to R11). It is never high together with `sw_en_o`.
- R6: A code of 142 or more, sampled in a non-powered mode, gives INRUSH on the next edge. `sw_en_o` is high in INRUSH and POWER (subject to R11).
- R7: In INRUSH, POWER or THERMAL the block leaves for the band-decoded mode only on the sample where the code has been below 124 for DEGLITCH_CYC+1 consecutive samples. Any sample at 124 or above restarts the count. Codes 124..141 keep the mode.
- R8: `lim_norm_o` is 0 when INRUSH is entered. It goes to 1 on the edge after `sw_full_i` is sampled high in INRUSH, and it stays 1 through POWER.
- R9: `pg_sink_o` is high in INRUSH and THERMAL. INRUSH moves to POWER only after TDELAY_CYC+1 cycles in INRUSH, and only on a sample with `sw_full_i` high.
- R10: `ot_trip_i` sampled in INRUSH or POWER gives THERMAL, which has the switch off and power-good held. From THERMAL, `ot_clear_i` gives INRUSH.
- R11: While `wall_i` is high and the code is 41 or more, `sw_en_o` and `cls_en_o` are low. With a code of 40 or less, `wall_i` has no effect.
- R12: An expired undervoltage count takes precedence over thermal trip and recovery, and thermal takes precedence over the move from INRUSH to POWER.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vin_code_i | input | VW | Input voltage code, 0.25 V per LSB |
| sw_full_i | input | 1 | Isolation switch fully enhanced |
| ot_trip_i | input | 1 | Junction above trip temperature |
| ot_clear_i | input | 1 | Junction below recovery temperature |
| wall_i | input | 1 | Wall adapter voltage present |
| mode_o | output | 3 | Current operating mode |
| sig_pd_o | output | 1 | Signature pull-down enable |
| cls_en_o | output | 1 | Classification sink enable |
| sw_en_o | output | 1 | Isolation switch enable |
| lim_norm_o | output | 1 | Current-limit select: 1 normal, 0 inrush |
| pg_sink_o | output | 1 | Power-good sink enable (converter held off) |

## Verification
The assertions assume every input is two-valued from the first edge and settles between edges. They also assume the undervoltage and power-good counters start from a known reset, so the stimulus holds `rst_n` low over several edges before anything else happens. All inputs change only on the falling clock edge and are never left undriven. The thermal flags are raised one at a time, except for the precedence case, where a trip and an undervoltage are deliberately applied together.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  typedef enum logic [2:0] {
    MD_IDLE     = 3'd0,
    MD_DETECT   = 3'd1,
    MD_CLASSIFY = 3'd2,
    MD_MARK     = 3'd3,
    MD_INRUSH   = 3'd4,
    MD_POWER    = 3'd5,
    MD_THERMAL  = 3'd6
  } pd_mode_e;

  localparam int VIN_LSB_MV = 250;

  // smallest code at or above a voltage
  function automatic int mv_ceil(input int mv);
    return (mv + VIN_LSB_MV - 1) / VIN_LSB_MV;
  endfunction

  // largest code at or below a voltage
  function automatic int mv_floor(input int mv);
    return mv / VIN_LSB_MV;
  endfunction

  localparam int DET_LO_CODE  = mv_ceil(1400);
  localparam int DET_HI_CODE  = mv_floor(10100);
  localparam int MARK_LO_CODE = mv_ceil(5200);
  localparam int MARK_HI_CODE = mv_floor(12500);
  localparam int CLS_LO_CODE  = mv_ceil(12600);
  localparam int CLS_HI_CODE  = mv_floor(20000);
  localparam int ON_CODE      = mv_ceil(35400);
  localparam int OFF_CODE     = mv_ceil(31000);
  localparam int ADP_LO_CODE  = DET_HI_CODE + 1;

  function automatic logic in_band(input int code, input int lo, input int hi);
    return (code >= lo) && (code <= hi);
  endfunction

  // mode chosen from voltage bands when not powered
  function automatic pd_mode_e band_mode(input logic det, input logic cls,
                                         input logic mark, input pd_mode_e cur);
    if (cls)
      return MD_CLASSIFY;
    else if (mark && (cur == MD_CLASSIFY || cur == MD_MARK))
      return MD_MARK;
    else if (det)
      return MD_DETECT;
    else
      return MD_IDLE;
  endfunction

endpackage

// File: rtl/pd_vin_decode.sv
module pd_vin_decode
  import pd_seq_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic [VW-1:0] code_i,
  output logic          det_band_o,
  output logic          cls_band_o,
  output logic          mark_band_o,
  output logic          on_lvl_o,
  output logic          low_lvl_o,
  output logic          adp_band_o
);

  int code;
  assign code = int'(code_i);

  assign det_band_o  = in_band(code, DET_LO_CODE, DET_HI_CODE);
  assign cls_band_o  = in_band(code, CLS_LO_CODE, CLS_HI_CODE);
  assign mark_band_o = in_band(code, MARK_LO_CODE, MARK_HI_CODE);
  assign on_lvl_o    = code >= ON_CODE;
  assign low_lvl_o   = code < OFF_CODE;
  assign adp_band_o  = code >= ADP_LO_CODE;

endmodule

// File: rtl/pd_cycle_timer.sv
module pd_cycle_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i)
      cnt_q <= '0;
    else if (run_i && !done_o)
      cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pd_power_sequencer.sv
module pd_power_sequencer
  import pd_seq_pkg::*;
#(
  parameter int          VW           = 8,
  parameter int unsigned TDELAY_CYC   = 24_000_000,
  parameter int unsigned DEGLITCH_CYC = 7_500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] vin_code_i,
  input  logic          sw_full_i,
  input  logic          ot_trip_i,
  input  logic          ot_clear_i,
  input  logic          wall_i,
  output logic [2:0]    mode_o,
  output logic          sig_pd_o,
  output logic          cls_en_o,
  output logic          sw_en_o,
  output logic          lim_norm_o,
  output logic          pg_sink_o
);

  logic det_band, cls_band, mark_band, on_lvl, low_lvl, adp_band;

  pd_vin_decode #(.VW(VW)) u_dec (
    .code_i      (vin_code_i),
    .det_band_o  (det_band),
    .cls_band_o  (cls_band),
    .mark_band_o (mark_band),
    .on_lvl_o    (on_lvl),
    .low_lvl_o   (low_lvl),
    .adp_band_o  (adp_band)
  );

  pd_mode_e mode_q, mode_d;
  logic     lim_q, lim_d;

  // named internal events
  logic pwr_fam, in_inrush, dg_run, dg_done, dg_expired, pg_done, wall_gate;

  assign pwr_fam   = (mode_q == MD_INRUSH) || (mode_q == MD_POWER) || (mode_q == MD_THERMAL);
  assign in_inrush = (mode_q == MD_INRUSH);
  assign dg_run    = pwr_fam && low_lvl;
  assign wall_gate = wall_i && adp_band;

  pd_cycle_timer #(.LIMIT(DEGLITCH_CYC)) u_dg_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (!dg_run),
    .run_i   (dg_run),
    .done_o  (dg_done)
  );

  pd_cycle_timer #(.LIMIT(TDELAY_CYC)) u_pg_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (!in_inrush),
    .run_i   (in_inrush),
    .done_o  (pg_done)
  );

  assign dg_expired = dg_run && dg_done;

  always_comb begin
    mode_d = mode_q;
    if (pwr_fam) begin
      if (dg_expired)
        mode_d = band_mode(det_band, cls_band, mark_band, MD_IDLE);
      else if (mode_q != MD_THERMAL && ot_trip_i)
        mode_d = MD_THERMAL;
      else if (mode_q == MD_THERMAL && ot_clear_i)
        mode_d = MD_INRUSH;
      else if (in_inrush && pg_done && sw_full_i)
        mode_d = MD_POWER;
    end else if (on_lvl) begin
      mode_d = MD_INRUSH;
    end else begin
      mode_d = band_mode(det_band, cls_band, mark_band, mode_q);
    end
  end

  always_comb begin
    lim_d = ((mode_d == MD_INRUSH) || (mode_d == MD_POWER)) &&
            (lim_q || (in_inrush && sw_full_i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MD_IDLE;
      lim_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      lim_q  <= lim_d;
    end
  end

  assign mode_o     = mode_q;
  assign sig_pd_o   = (mode_q == MD_DETECT);
  assign cls_en_o   = (mode_q == MD_CLASSIFY) && !wall_gate;
  assign sw_en_o    = ((mode_q == MD_INRUSH) || (mode_q == MD_POWER)) && !wall_gate;
  assign lim_norm_o = lim_q;
  assign pg_sink_o  = (mode_q == MD_INRUSH) || (mode_q == MD_THERMAL);

  // R5
  cls_sw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cls_en_o && sw_en_o));

  // R4
  sig_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_pd_o |-> $past(det_band));

  // R9
  pg_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_POWER && $past(mode_q) == MD_INRUSH) |-> ($past(pg_done) && $past(sw_full_i)));

  // R7
  uvlo_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_fam) && !pwr_fam) |-> $past(dg_expired));

  // R10
  hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_THERMAL) |-> (!sw_en_o && pg_sink_o));

  // R8
  lim_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lim_norm_o) |-> $past(sw_full_i));

endmodule

// File: tb/pd_power_sequencer_tb.sv
module pd_power_sequencer_tb_top;

  localparam int TD = 12;
  localparam int DG = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] code = 8'd0;
  logic       sw_full = 1'b0, ot_trip = 1'b0, ot_clear = 1'b0, wall = 1'b0;
  logic [2:0] mode_o;
  logic       sig_pd_o, cls_en_o, sw_en_o, lim_norm_o, pg_sink_o;

  always #2 clk = ~clk;

  pd_power_sequencer #(.VW(8), .TDELAY_CYC(TD), .DEGLITCH_CYC(DG)) dut_i (
    .clk(clk), .rst_n(rst_n), .vin_code_i(code), .sw_full_i(sw_full),
    .ot_trip_i(ot_trip), .ot_clear_i(ot_clear), .wall_i(wall),
    .mode_o(mode_o), .sig_pd_o(sig_pd_o), .cls_en_o(cls_en_o),
    .sw_en_o(sw_en_o), .lim_norm_o(lim_norm_o), .pg_sink_o(pg_sink_o)
  );

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // reference state
  int m_mode = 0, m_low_run = 0, m_in_rush = 0;
  bit m_lim = 0;

  function automatic int ref_band(int c, int prev);
    if (c >= 51 && c <= 80) return 2;
    if (c >= 21 && c <= 50 && (prev == 2 || prev == 3)) return 3;
    if (c >= 6 && c <= 40) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    int nxt;
    bit powered;
    if (!rst_n) begin
      m_mode = 0; m_low_run = 0; m_in_rush = 0; m_lim = 0;
    end else begin
      powered = (m_mode == 4 || m_mode == 5 || m_mode == 6);
      if (powered && code < 124) m_low_run++; else m_low_run = 0;
      nxt = m_mode;
      if (powered) begin
        if (m_low_run > DG) nxt = ref_band(code, 0);
        else if (m_mode != 6 && ot_trip) nxt = 6;
        else if (m_mode == 6 && ot_clear) nxt = 4;
        else if (m_mode == 4 && m_in_rush > TD && sw_full) nxt = 5;
      end else if (code >= 142) nxt = 4;
      else nxt = ref_band(code, m_mode);
      if (nxt != 4 && nxt != 5) m_lim = 0;
      else if (m_mode == 4 && sw_full) m_lim = 1;
      if (nxt == 4) m_in_rush = (m_mode == 4) ? m_in_rush + 1 : 1;
      else m_in_rush = 0;
      if (!(nxt == 4 || nxt == 5 || nxt == 6)) m_low_run = 0;
      m_mode = nxt;
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, 1 ns after the rising edge
  always @(posedge clk) begin
    bit gate;
    cycles++;
    #1;
    if (!done) begin
      gate = wall && code >= 41;
      check(int'(mode_o) == m_mode, "R2", "mode", int'(mode_o), m_mode);
      check(sig_pd_o == (m_mode == 1), "R4", "sig_pd", sig_pd_o, m_mode == 1);
      check(cls_en_o == (m_mode == 2 && !gate), "R5", "cls_en", cls_en_o, m_mode == 2 && !gate);
      check(sw_en_o == ((m_mode == 4 || m_mode == 5) && !gate), "R6", "sw_en",
            sw_en_o, (m_mode == 4 || m_mode == 5) && !gate);
      check(lim_norm_o == m_lim, "R8", "lim_norm", lim_norm_o, m_lim);
      check(pg_sink_o == (m_mode == 4 || m_mode == 6), "R9", "pg_sink",
            pg_sink_o, m_mode == 4 || m_mode == 6);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic want_mode(string tag, int exp);
    check(int'(mode_o) == exp, tag, "mode", int'(mode_o), exp);
  endtask

  task automatic power_up();
    code = 8'd160; sw_full = 1'b1;
    run(TD + 4);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    run(4);
    // R1 reset state
    want_mode("R1", 0);
    check(!sig_pd_o && !cls_en_o && !sw_en_o && !lim_norm_o && !pg_sink_o, "R1", "enables",
          {sig_pd_o, cls_en_o, sw_en_o, lim_norm_o, pg_sink_o}, 0);
    rst_n = 1'b1;

    code = 8'd20; run(3); want_mode("R2", 1);
    check(sig_pd_o, "R4", "sig in detect", sig_pd_o, 1);
    code = 8'd60; run(3); want_mode("R2", 2);
    code = 8'd30; run(3); want_mode("R3", 3);
    code = 8'd45; run(3); want_mode("R3", 3);
    code = 8'd4;  run(3); want_mode("R2", 0);
    code = 8'd45; run(3); want_mode("R3", 0);
    code = 8'd30; run(3); want_mode("R3", 1);

    // inrush without enhancement, then enhancement
    code = 8'd160; sw_full = 1'b0; run(30);
    want_mode("R6", 4);
    check(lim_norm_o == 1'b0, "R8", "lim before enhance", lim_norm_o, 0);
    sw_full = 1'b1; run(1); want_mode("R9", 5);
    check(lim_norm_o, "R8", "lim after enhance", lim_norm_o, 1);

    // R7 dips
    code = 8'd110; run(DG); code = 8'd160; run(3); want_mode("R7", 5);
    code = 8'd130; run(40); want_mode("R7", 5);
    code = 8'd110; run(3); code = 8'd160; run(1); code = 8'd110; run(5); want_mode("R7", 5);
    code = 8'd160; run(1);
    code = 8'd110; run(DG); want_mode("R7", 5);
    run(1); want_mode("R7", 0);

    // R9 minimum inrush with early enhancement
    code = 8'd160; sw_full = 1'b1; run(1); want_mode("R9", 4);
    check(!lim_norm_o, "R8", "lim on entry", lim_norm_o, 0);
    run(1);
    check(lim_norm_o, "R8", "lim after first enhanced sample", lim_norm_o, 1);
    run(TD - 1); want_mode("R9", 4);
    run(1); want_mode("R9", 5);

    // R10 thermal
    ot_trip = 1'b1; run(2); want_mode("R10", 6);
    check(!sw_en_o && pg_sink_o, "R10", "switch off, pg held", sw_en_o, 0);
    ot_trip = 1'b0; run(3); want_mode("R10", 6);
    ot_clear = 1'b1; run(1); want_mode("R10", 4);
    ot_clear = 1'b0; run(TD + 2); want_mode("R10", 5);

    // R11 wall adapter
    wall = 1'b1; run(1); check(!sw_en_o, "R11", "switch gated", sw_en_o, 0);
    want_mode("R11", 5);
    wall = 1'b0; run(1); check(sw_en_o, "R11", "switch back", sw_en_o, 1);
    code = 8'd60; run(DG + 2); want_mode("R11", 2);
    wall = 1'b1; run(1); check(!cls_en_o, "R11", "class sink gated", cls_en_o, 0);
    code = 8'd20; run(2); want_mode("R11", 1);
    check(sig_pd_o, "R11", "no effect below 41", sig_pd_o, 1);
    wall = 1'b0;

    // R12 precedence: UVLO expiry over thermal
    power_up(); want_mode("R12", 5);
    code = 8'd110; ot_trip = 1'b1; run(1); want_mode("R12", 6);
    run(DG - 1); want_mode("R12", 6);
    run(1); want_mode("R12", 0);
    ot_trip = 1'b0;

    // R12 thermal over inrush exit
    code = 8'd160; sw_full = 1'b1; run(TD + 1); want_mode("R12", 4);
    ot_trip = 1'b1; run(1); want_mode("R12", 6);
    ot_trip = 1'b0;

    // R1 reset while powered
    ot_clear = 1'b1; run(TD + 3); ot_clear = 1'b0;
    rst_n = 1'b0; run(2);
    want_mode("R1", 0);
    check(!sw_en_o && !pg_sink_o && !lim_norm_o, "R1", "reset while powered", sw_en_o, 0);
    rst_n = 1'b1; code = 8'd0; run(2);

    done = 1;
    summary();
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      summary();
    end
  end

endmodule